// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a processor-style timer interrupt source. A 32-bit counter advances by one on each cycle where a single-cycle tick enable is high and counting is not frozen. A 32-bit compare register holds a target value. When the counter steps onto the compare value, the block raises a timer request. That request appears on one of eight interrupt lines, chosen by a 3-bit routing input.

Control logic writes the counter and the compare register through a shared data bus with two write strobes. It reads both registers back on dedicated outputs. A 3-bit revision input decides whether a match also sets a cause-style pending bit, or only drives the interrupt line. A write to the compare register acknowledges the request. A request is raised only when the counter advances onto the compare value, so loading the counter with a value equal to the compare value never causes an immediate match.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 1, the compare register reads 0, the pending bit is 0 and all eight interrupt lines are 0.
- R2: When tickEn is 1, countDisable is 0 and no counter write is present, the counter becomes its previous value plus one on the next edge. The count wraps from 0xFFFFFFFF to 0.
- R3: While countDisable is 1, the counter keeps its value and no match can raise the request.
- R4: When an increment makes the counter equal to the compare value, the request is active from that same edge. The line whose index equals irqRoute is driven high.
- R5: A match sets causePending only when archRev equals 1. For any other archRev value, only the interrupt line is driven.
- R6: Any compare write loads wrData and drops the interrupt request. The same write clears causePending only when archRev equals 1; for other archRev values, causePending keeps its value.
- R7: A counter write loads wrData and takes priority over an increment in the same cycle. A match that the increment would have caused in that cycle is suppressed. Loading a value equal to the compare value causes no match; the next match needs the counter to advance around to the compare value again.
- R8: At most one interrupt line is high at any time. When irqRoute changes while the request is active, the request moves to the newly selected line without delay.
- R9: A compare write in the same cycle as a match clears the request, and the request stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Single-cycle count enable |
| countDisable | input | 1 | Freezes the counter while high |
| archRev | input | 3 | Revision field; value 1 exposes the pending bit |
| irqRoute | input | 3 | Index of the interrupt line that carries the request |
| cntWrEn | input | 1 | Load the counter from wrData |
| cmpWrEn | input | 1 | Load the compare register from wrData and acknowledge |
| wrData | input | 32 | Write data for both registers |
| countOut | output | 32 | Current counter value |
| compareOut | output | 32 | Current compare value |
| causePending | output | 1 | Cause-style pending bit |
| irqLines | output | 8 | Interrupt outputs, at most one high |

## Verification
Two events can land on the same edge: a match caused by an increment, and a register write. The bench provokes both collisions. First it sets the counter one below the compare value, then pulses tickEn together with a counter write. The counter must show the written value and no line may rise. Second, it pulses tickEn together with a compare write. The counter must land on the old target while the request stays low. Both outcomes are judged one edge later, on the register read-back outputs and the interrupt lines.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef struct packed {
    logic incCount;
    logic loadCount;
    logic loadCompare;
  } tmrStrobe_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] compareVal,
  output logic             hitAhead
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] countNext;
  assign countNext = countVal + ONE;
  assign hitAhead  = (countNext == compareVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= CNT_RST;
    end else if (strobe.loadCount) begin
      countVal <= wrData;
    end else if (strobe.incCount) begin
      countVal <= countNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareVal <= '0;
    end else if (strobe.loadCompare) begin
      compareVal <= wrData;
    end
  end
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int REV_W    = 3,
  parameter int PEND_REV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             countDisable,
  input  logic [REV_W-1:0] archRev,
  input  logic             cntWrEn,
  input  logic             cmpWrEn,
  input  logic             hitAhead,
  output tmrStrobe_t       strobe,
  output logic             irqReq,
  output logic             pendBit
);
  logic revShowsPend;
  logic matchEvt;

  assign revShowsPend = (archRev == REV_W'(PEND_REV));

  always_comb begin
    strobe.loadCount   = cntWrEn;
    strobe.incCount    = tickEn && !countDisable && !cntWrEn;
    strobe.loadCompare = cmpWrEn;
  end

  // a match is an increment onto the target; writes win over it
  assign matchEvt = strobe.incCount && hitAhead && !cmpWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
    end else if (cmpWrEn) begin
      irqReq <= 1'b0;
    end else if (matchEvt) begin
      irqReq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBit <= 1'b0;
    end else if (cmpWrEn && revShowsPend) begin
      pendBit <= 1'b0;
    end else if (matchEvt && revShowsPend) begin
      pendBit <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_route.sv
module cmp_timer_route #(
  parameter int ROUTE_W = 3,
  localparam int LINES  = 1 << ROUTE_W
) (
  input  logic               irqReq,
  input  logic [ROUTE_W-1:0] irqRoute,
  output logic [LINES-1:0]   irqLines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irqLines[i] = irqReq && (irqRoute == ROUTE_W'(i));
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int ROUTE_W  = 3,
  parameter int REV_W    = 3,
  parameter int PEND_REV = 1,
  localparam int LINES   = 1 << ROUTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               countDisable,
  input  logic [REV_W-1:0]   archRev,
  input  logic [ROUTE_W-1:0] irqRoute,
  input  logic               cntWrEn,
  input  logic               cmpWrEn,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   countOut,
  output logic [CNT_W-1:0]   compareOut,
  output logic               causePending,
  output logic [LINES-1:0]   irqLines
);
  tmrStrobe_t strobe;
  logic       hitAhead;
  logic       irqReq;

  cmp_timer_ctrl #(.REV_W(REV_W), .PEND_REV(PEND_REV)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countDisable(countDisable),
    .archRev(archRev), .cntWrEn(cntWrEn), .cmpWrEn(cmpWrEn),
    .hitAhead(hitAhead), .strobe(strobe), .irqReq(irqReq),
    .pendBit(causePending)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .countVal(countOut), .compareVal(compareOut), .hitAhead(hitAhead)
  );

  cmp_timer_route #(.ROUTE_W(ROUTE_W)) u_route (
    .irqReq(irqReq), .irqRoute(irqRoute), .irqLines(irqLines)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int ROUTE_W = 3,
  parameter int REV_W   = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      tickEn,
  input logic                      countDisable,
  input logic [REV_W-1:0]          archRev,
  input logic                      cntWrEn,
  input logic                      cmpWrEn,
  input logic [CNT_W-1:0]          wrData,
  input logic [CNT_W-1:0]          countOut,
  input logic                      causePending,
  input logic [(1<<ROUTE_W)-1:0]   irqLines
);
  // R8
  lines_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !countDisable && !cntWrEn) |=> countOut == $past(countOut) + CNT_W'(1));

  // R3
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countDisable && !cntWrEn) |=> $stable(countOut));

  // R3
  frozen_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countDisable && !cntWrEn) |=> !$rose(|irqLines));

  // R6
  cmp_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrEn |=> irqLines == '0);

  // R7
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (countOut == $past(wrData)) && !$rose(|irqLines));

  // R5
  pend_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(causePending) |-> $past(archRev) == REV_W'(1));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W), .REV_W(REV_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .countDisable(countDisable),
  .archRev(archRev), .cntWrEn(cntWrEn), .cmpWrEn(cmpWrEn), .wrData(wrData),
  .countOut(countOut), .causePending(causePending), .irqLines(irqLines)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, countDisable = 1'b0, cntWrEn = 1'b0, cmpWrEn = 1'b0;
  logic [2:0]  archRev = 3'd0, irqRoute = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] countOut, compareOut;
  logic        causePending;
  logic [7:0]  irqLines;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .countDisable(countDisable),
    .archRev(archRev), .irqRoute(irqRoute), .cntWrEn(cntWrEn), .cmpWrEn(cmpWrEn),
    .wrData(wrData), .countOut(countOut), .compareOut(compareOut),
    .causePending(causePending), .irqLines(irqLines)
  );

  typedef struct packed {
    logic        cw;
    logic        pw;
    logic        tk;
    logic        ds;
    logic [2:0]  rev;
    logic [2:0]  rt;
    logic [31:0] d;
    logic [31:0] eCnt;
    logic [31:0] eCmp;
    logic        eP;
    logic [7:0]  eL;
  } vec_t;

  // R4 R5 R3 R8 R6 walked in order
  localparam vec_t TBL [11] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 32'h5,  32'h1, 32'h5,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 32'h0,  32'h2, 32'h5,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 32'h0,  32'h3, 32'h5,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 32'h0,  32'h4, 32'h5,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 32'h0,  32'h5, 32'h5,  1'b1, 8'h04},
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd2, 32'h0,  32'h5, 32'h5,  1'b1, 8'h04},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd6, 32'h0,  32'h6, 32'h5,  1'b1, 8'h40},
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd6, 32'h8,  32'h6, 32'h8,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd6, 32'h0,  32'h7, 32'h8,  1'b0, 8'h00},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd6, 32'h0,  32'h8, 32'h8,  1'b0, 8'h40},
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd6, 32'h20, 32'h8, 32'h20, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [72:0] act, input logic [72:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual cnt=%h cmp=%h pend=%b lines=%h expected cnt=%h cmp=%h pend=%b lines=%h",
               tag, act[72:41], act[40:9], act[8], act[7:0],
               exp[72:41], exp[40:9], exp[8], exp[7:0]);
    end
  endtask

  function automatic logic [72:0] state();
    return {countOut, compareOut, causePending, irqLines};
  endfunction

  task automatic step(input logic cw, input logic pw, input logic tk, input logic ds,
                      input logic [2:0] rev, input logic [2:0] rt, input logic [31:0] d);
    cntWrEn = cw; cmpWrEn = pw; tickEn = tk; countDisable = ds;
    archRev = rev; irqRoute = rt; wrData = d;
    @(negedge clk);
    cntWrEn = 1'b0; cmpWrEn = 1'b0; tickEn = 1'b0; countDisable = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    chk("R1", state(), {32'h1, 32'h0, 1'b0, 8'h00});

    foreach (TBL[i]) begin
      step(TBL[i].cw, TBL[i].pw, TBL[i].tk, TBL[i].ds, TBL[i].rev, TBL[i].rt, TBL[i].d);
      chk($sformatf("R4/R5/R6 row %0d", i), state(), {TBL[i].eCnt, TBL[i].eCmp, TBL[i].eP, TBL[i].eL});
    end

    // R7 load equal to compare: no match
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'h20);
    chk("R7 load eq", state(), {32'h20, 32'h20, 1'b0, 8'h00});
    step(0, 0, 1, 0, 3'd0, 3'd6, 32'h0);
    chk("R7 past target", state(), {32'h21, 32'h20, 1'b0, 8'h00});
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'h1F);
    step(0, 0, 1, 0, 3'd0, 3'd6, 32'h0);
    chk("R4 approach", state(), {32'h20, 32'h20, 1'b0, 8'h40});

    // R2 wrap onto compare 0
    step(0, 1, 0, 0, 3'd0, 3'd6, 32'h0);
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'hFFFF_FFFF);
    step(0, 0, 1, 0, 3'd0, 3'd6, 32'h0);
    chk("R2 wrap", state(), {32'h0, 32'h0, 1'b0, 8'h40});

    // R9 compare write with match
    step(0, 1, 0, 0, 3'd0, 3'd6, 32'h30);
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'h2F);
    step(0, 1, 1, 0, 3'd0, 3'd6, 32'h40);
    chk("R9 collide", state(), {32'h30, 32'h40, 1'b0, 8'h00});
    step(0, 0, 0, 0, 3'd0, 3'd6, 32'h0);
    chk("R9 stays low", state(), {32'h30, 32'h40, 1'b0, 8'h00});

    // R7 count write with match
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'h3F);
    step(1, 0, 1, 0, 3'd0, 3'd6, 32'h100);
    chk("R7 collide", state(), {32'h100, 32'h40, 1'b0, 8'h00});

    // R3 disabled tick onto target
    step(1, 0, 0, 0, 3'd0, 3'd6, 32'h3F);
    step(0, 0, 1, 1, 3'd0, 3'd6, 32'h0);
    chk("R3 frozen", state(), {32'h3F, 32'h40, 1'b0, 8'h00});
    step(0, 0, 1, 0, 3'd0, 3'd6, 32'h0);
    chk("R3 resume", state(), {32'h40, 32'h40, 1'b0, 8'h40});

    // R5 R6 revision-dependent pending
    step(0, 1, 0, 0, 3'd1, 3'd1, 32'h41);
    step(0, 0, 1, 0, 3'd1, 3'd1, 32'h0);
    chk("R5 pend set", state(), {32'h41, 32'h41, 1'b1, 8'h02});
    step(0, 1, 0, 0, 3'd3, 3'd1, 32'h50);
    chk("R6 other rev keeps pend", state(), {32'h41, 32'h50, 1'b1, 8'h00});
    step(0, 1, 0, 0, 3'd1, 3'd1, 32'h50);
    chk("R6 rev1 clears pend", state(), {32'h41, 32'h50, 1'b0, 8'h00});

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule